// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable ratio N = P·B + A and emits one output pulse per N input cycles, for use as the feedback input of a phase comparator. Division is split between a dual-modulus prescaler, which counts input cycles in groups of P or P+1, and two slower counters that run once per prescaler period: a 5-bit swallow count A and a 13-bit main count B. In each output cycle the first A prescaler periods are P+1 cycles long and the remaining B−A periods are P cycles long. The select input chooses P = 8 (modulus pair 8/9) or P = 32 (pair 32/33). The prescaler is built from a synchronous divide-by-4/5 core, and a stage counter repeats that core to reach the wider modulus.

Software supplies A, B and the select value with a one-cycle load strobe. A legal setting is held in a shadow register and takes effect only when the current output cycle ends, so a period is never cut short. An illegal setting (B below 3, or B below A, which would leave gaps in the reachable ratios) raises an error flag and is discarded.

Top module: `pswallow_div`

## Requirements
- R1: With `cfg_sel32` = 0 (P = 8), the spacing between consecutive rising edges of `div_out` is 8·B + A input clock cycles.
- R2: With `cfg_sel32` = 1 (P = 32), the spacing between consecutive rising edges of `div_out` is 32·B + A input clock cycles.
- R3: Each `div_out` pulse is high for exactly one prescaler period: P+1 cycles when A > 0 and P cycles when A = 0.
- R4: Any setting with 0 ≤ A ≤ 31, 3 ≤ B ≤ 8191 and B ≥ A is accepted, and `cfg_err` reads 0 on the cycle after its load.
- R5: A load with B < 3 or B < A sets `cfg_err` to 1 on the cycle after the load and is discarded; the output period stays unchanged.
- R6: A setting accepted during an output cycle leaves that cycle at its old length and applies from the next rising edge of `div_out`.
- R7: When several loads arrive within one output cycle, the last legal one is applied and illegal ones in between do not displace it.
- R8: A legal load clears `cfg_err` on the cycle after the load.
- R9: While `rst` is high, `div_out` and `cfg_err` are 0. After reset the divider runs with A = 0, B = 3, P = 8 (N = 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that offers a new setting |
| cfg_sel32 | input | 1 | Prescaler select: 0 gives 8/9, 1 gives 32/33 |
| cfg_a | input | 5 | Swallow count A (0 to 31) |
| cfg_b | input | 13 | Main count B (3 to 8191, not below A) |
| div_out | output | 1 | Divided output, one pulse per N input cycles |
| cfg_err | output | 1 | High after a rejected load, cleared by a legal one |

## Verification
The hardest case to reach from the ports is a setting change that must land on an output-cycle boundary while a period is already running, with the prescaler modulus switching in the same step. The stimulus waits for an observed rising edge of `div_out`, loads a setting a cycle later, and then times two full intervals. The first interval must keep the old ratio and the second must show the new one, so a setting applied too early or too late shows up as a wrong interval. Repeated loads inside a single period, and illegal loads placed after a pending legal one, are timed the same way.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Field widths of the programmed setting
  localparam int unsigned A_W = 5;
  localparam int unsigned B_W = 13;

  typedef struct packed {
    logic           sel32;
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
  } div_cfg_t;

  // A setting is legal when B reaches the floor and B is not below A
  function automatic logic cfg_ok(input logic [A_W-1:0] a,
                                  input logic [B_W-1:0] b,
                                  input int unsigned    min_b);
    logic [B_W-1:0] a_ext;
    a_ext  = B_W'(a);
    cfg_ok = (32'(b) >= min_b) && (b >= a_ext);
  endfunction

endpackage

// File: rtl/ps_prescaler.sv
// Dual-modulus prescaler: a 4/5 core repeated over a number of stages.
// One stage per period uses the long core count when mod_hi is set.
module ps_prescaler #(
  parameter int unsigned CORE      = 4,
  parameter int unsigned LO_STAGES = 2,
  parameter int unsigned HI_STAGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  input  logic mod_hi,
  output logic tick
);

  localparam int unsigned CW    = $clog2(CORE + 1);
  localparam int unsigned EXT_W = (HI_STAGES > 1) ? $clog2(HI_STAGES) : 1;
  localparam int unsigned GAP_W = $clog2(HI_STAGES * CORE + 2) + 1;

  logic [CW-1:0]    core_q;
  logic [EXT_W-1:0] stage_q;
  logic [EXT_W-1:0] stage_last;
  logic [CW-1:0]    core_top;
  logic             last_stage;
  logic             core_end;

  assign stage_last = sel_hi ? EXT_W'(HI_STAGES - 1) : EXT_W'(LO_STAGES - 1);
  assign last_stage = (stage_q == stage_last);
  // the extra input cycle is spent in the final stage of the period
  assign core_top   = (last_stage && mod_hi) ? CW'(CORE) : CW'(CORE - 1);
  assign core_end   = (core_q == core_top);
  assign tick       = core_end && last_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q  <= '0;
      stage_q <= '0;
    end else if (core_end) begin
      core_q  <= '0;
      stage_q <= last_stage ? '0 : stage_q + 1'b1;
    end else begin
      core_q  <= core_q + 1'b1;
    end
  end

  // Checker: cycles between ticks must equal the selected modulus
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_want;

  always_ff @(posedge clk) begin
    if (rst)       gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  assign gap_want = GAP_W'((sel_hi ? HI_STAGES : LO_STAGES) * CORE - 1) + GAP_W'(mod_hi);

  // R1 R2: each prescaler period is P or P+1 input cycles
  p_modulus_r1: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == gap_want));

  p_core_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(core_q) <= CORE);

endmodule

// File: rtl/ps_swallow.sv
// Swallow (A) and main (B) counters, advanced once per prescaler period.
module ps_swallow #(
  parameter int unsigned A_W   = 5,
  parameter int unsigned B_W   = 13,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_B = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           mod_hi,
  output logic           boundary
);

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           last_period;

  assign last_period = (b_q == B_W'(1));
  assign boundary    = tick && last_period;
  assign mod_hi      = (a_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= A_W'(RST_A);
      b_q <= B_W'(RST_B);
    end else if (boundary) begin
      a_q <= ld_a;
      b_q <= ld_b;
    end else if (tick) begin
      b_q <= b_q - 1'b1;
      if (a_q != '0) a_q <= a_q - 1'b1;
    end
  end

  // R4: a legal setting keeps the swallow count at or below the main count
  p_a_within_b_r4: assert property (@(posedge clk) disable iff (rst)
    B_W'(a_q) <= b_q);

  // R4: the main count never runs dry inside a cycle
  p_b_live_r4: assert property (@(posedge clk) disable iff (rst)
    b_q != '0);

endmodule

// File: rtl/ps_cfg_shadow.sv
// Validates loaded settings, holds the pending one and swaps it in at
// the output-cycle boundary.
module ps_cfg_shadow
  import pswallow_pkg::*;
#(
  parameter int unsigned MIN_B   = 3,
  parameter int unsigned RST_A   = 0,
  parameter int unsigned RST_B   = 3,
  parameter bit          RST_SEL = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  div_cfg_t wr_cfg,
  input  logic     boundary,
  output div_cfg_t act_cfg,
  output div_cfg_t nxt_cfg,
  output logic     err
);

  localparam div_cfg_t RST_CFG = '{sel32: RST_SEL, a: A_W'(RST_A), b: B_W'(RST_B)};

  div_cfg_t pend_q;
  logic     pend_v;
  logic     wr_ok;

  assign wr_ok   = cfg_ok(wr_cfg.a, wr_cfg.b, MIN_B);
  assign nxt_cfg = pend_v ? pend_q : act_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg <= RST_CFG;
      pend_q  <= RST_CFG;
      pend_v  <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (boundary) begin
        act_cfg <= nxt_cfg;
        pend_v  <= 1'b0;
      end
      if (load) begin
        if (wr_ok) begin
          pend_q <= wr_cfg;
          pend_v <= 1'b1;
          err    <= 1'b0;
        end else begin
          err    <= 1'b1;
        end
      end
    end
  end

  // R5: a rejected load raises the flag
  p_bad_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_ok) |=> err);

  // R8: an accepted load clears the flag
  p_good_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (load && wr_ok) |=> !err);

  // R6: the active setting only moves at a boundary
  p_hold_active_r6: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_cfg));

  // R5: the active setting is always legal
  p_active_legal_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_ok(act_cfg.a, act_cfg.b, MIN_B));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int unsigned CORE      = 4,
  parameter int unsigned LO_STAGES = 2,
  parameter int unsigned HI_STAGES = 8,
  parameter int unsigned MIN_B     = 3,
  parameter int unsigned RST_A     = 0,
  parameter int unsigned RST_B     = 3,
  parameter bit          RST_SEL   = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_load,
  input  logic           cfg_sel32,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  output logic           div_out,
  output logic           cfg_err
);

  div_cfg_t wr_cfg;
  div_cfg_t act_cfg;
  div_cfg_t nxt_cfg;
  logic     tick;
  logic     mod_hi;
  logic     boundary;

  assign wr_cfg = '{sel32: cfg_sel32, a: cfg_a, b: cfg_b};

  ps_cfg_shadow #(
    .MIN_B   (MIN_B),
    .RST_A   (RST_A),
    .RST_B   (RST_B),
    .RST_SEL (RST_SEL)
  ) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .wr_cfg   (wr_cfg),
    .boundary (boundary),
    .act_cfg  (act_cfg),
    .nxt_cfg  (nxt_cfg),
    .err      (cfg_err)
  );

  ps_prescaler #(
    .CORE      (CORE),
    .LO_STAGES (LO_STAGES),
    .HI_STAGES (HI_STAGES)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .sel_hi (act_cfg.sel32),
    .mod_hi (mod_hi),
    .tick   (tick)
  );

  ps_swallow #(
    .A_W   (A_W),
    .B_W   (B_W),
    .RST_A (RST_A),
    .RST_B (RST_B)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ld_a     (nxt_cfg.a),
    .ld_b     (nxt_cfg.b),
    .mod_hi   (mod_hi),
    .boundary (boundary)
  );

  // Output is high for the first prescaler period of each output cycle
  always_ff @(posedge clk) begin
    if (rst)           div_out <= 1'b0;
    else if (boundary) div_out <= 1'b1;
    else if (tick)     div_out <= 1'b0;
  end

  // R6: a new output cycle starts with the setting that was next in line
  p_swap_on_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> (act_cfg == $past(nxt_cfg)));

  // R3: a pulse lasts longer than one input cycle
  p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |=> div_out);

endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
  import pswallow_pkg::*;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_load = 1'b0;
  logic           cfg_sel32 = 1'b0;
  logic [A_W-1:0] cfg_a = '0;
  logic [B_W-1:0] cfg_b = '0;
  logic           div_out;
  logic           cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pswallow_div u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_sel32 (cfg_sel32),
    .cfg_a     (cfg_a),
    .cfg_b     (cfg_b),
    .div_out   (div_out),
    .cfg_err   (cfg_err)
  );

  // {sel32, A, B, expected N}
  localparam int N_VEC = 10;
  localparam logic [36:0] VEC [N_VEC] = '{
    {1'b0, 5'd3,  13'd3,    18'd27},
    {1'b0, 5'd31, 13'd31,   18'd279},
    {1'b0, 5'd1,  13'd100,  18'd801},
    {1'b0, 5'd0,  13'd1000, 18'd8000},
    {1'b1, 5'd0,  13'd3,    18'd96},
    {1'b1, 5'd5,  13'd5,    18'd165},
    {1'b1, 5'd31, 13'd31,   18'd1023},
    {1'b1, 5'd31, 13'd40,   18'd1311},
    {1'b1, 5'd17, 13'd200,  18'd6417},
    {1'b0, 5'd3,  13'd3,    18'd27}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // returns at the negedge where a low-to-high change of div_out is seen
  task automatic wait_rise(output int t);
    logic p, c;
    p = div_out;
    forever begin
      @(negedge clk);
      c = div_out;
      if (c && !p) break;
      p = c;
    end
    t = cyc;
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (!div_out) break;
      w++;
    end
  endtask

  task automatic do_load(input bit sel, input int a, input int b);
    cfg_sel32 = sel;
    cfg_a     = A_W'(a);
    cfg_b     = B_W'(b);
    cfg_load  = 1'b1;
    @(negedge clk);
    cfg_load  = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, w, prev_n;
    repeat (3) @(negedge clk);
    chk("R9 reset div_out", int'(div_out), 0);
    chk("R9 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;

    wait_rise(t0);
    wait_rise(t1);
    chk("R9 default ratio", t1 - t0, 24);
    prev_n = 24;

    // table walk: R1/R2 ratio, R3 width, R4 acceptance, R6 old period kept
    for (int i = 0; i < N_VEC; i++) begin
      bit sel;
      int a, b, n;
      sel = VEC[i][36];
      a   = int'(VEC[i][35:31]);
      b   = int'(VEC[i][30:18]);
      n   = int'(VEC[i][17:0]);
      wait_rise(t0);
      do_load(sel, a, b);
      chk("R4 legal accepted", int'(cfg_err), 0);
      wait_rise(t1);
      chk("R6 running period kept", t1 - t0, prev_n);
      wait_rise(t2);
      chk(sel ? "R2 ratio P=32" : "R1 ratio P=8", t2 - t1, n);
      pulse_width(w);
      chk("R3 pulse width", w, (sel ? 32 : 8) + ((a != 0) ? 1 : 0));
      prev_n = n;
    end

    // R5: illegal settings rejected, period unchanged (active N=27)
    wait_rise(t0);
    do_load(1'b0, 0, 2);
    chk("R5 B below floor flagged", int'(cfg_err), 1);
    do_load(1'b0, 10, 9);
    chk("R5 B below A flagged", int'(cfg_err), 1);
    wait_rise(t1);
    chk("R5 period unchanged", t1 - t0, 27);
    wait_rise(t2);
    chk("R5 period unchanged later", t2 - t1, 27);

    // R8: legal load clears the flag and takes effect
    do_load(1'b0, 0, 5);
    chk("R8 flag cleared", int'(cfg_err), 0);
    wait_rise(t0);
    chk("R6 old period before swap", t0 - t2, 27);
    wait_rise(t1);
    chk("R8 new ratio", t1 - t0, 40);

    // R7: last legal load in a period wins, illegal one ignored
    do_load(1'b0, 0, 10);
    do_load(1'b1, 0, 4);
    do_load(1'b0, 9, 4);
    chk("R7 late illegal flagged", int'(cfg_err), 1);
    wait_rise(t0);
    chk("R7 running period kept", t0 - t1, 40);
    wait_rise(t2);
    chk("R7 last legal applied", t2 - t0, 128);

    // R4 upper bound accepted, then reset restores defaults (R9)
    do_load(1'b0, 0, 2);
    do_load(1'b0, 31, 8191);
    chk("R4 maximum B accepted", int'(cfg_err), 0);
    do_load(1'b0, 5, 4);
    chk("R5 flag set before reset", int'(cfg_err), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 mid-run reset div_out", int'(div_out), 0);
    chk("R9 mid-run reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    wait_rise(t0);
    wait_rise(t1);
    chk("R9 default after reset", t1 - t0, 24);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule